// File: doc/BRIEF.md
# Camera Link Transmitter Bring-Up Sequencer

This block is the control sequencer that takes a four-lane serial camera transmitter and its PHY from cold to streaming. When a start pulse arrives it latches the active frame width and height. It then takes the PHY through an ordered reset and release, and picks the lane bit rate from the frame size. It looks up the PHY frequency-range code by a first-fit threshold search and sends that code as one write request to an external test-interface master.

After timed settling waits it powers the PHY and checks PLL lock. It programs the packet word count, the data type and the lane-enable mask, and then enables the link. It clears the error flags, leaves bypass mode and reads the raw error status. A lock failure or a nonzero error status starts a full reconfiguration. There are at most three attempts in total, and the block then reports success or failure. A stop pulse drops the PHY and link enables. Every change to an enable or to bypass mode comes with a one-cycle config-done strobe, so the shadowed settings downstream take effect together.

Top module: `cam_tx_bringup`

## Requirements
- R1: The lane rate is 1250 Mb/s when the latched frame is exactly 3840 wide and 2160 high, and 750 Mb/s for any other size, including the transposed 2160×3840.
- R2: The 6-bit range code is the code of the first table entry whose rate limit is at or above the lane rate; if none qualifies, the last entry's code (0x3C) is used. This gives 0x09 for 750 Mb/s and 0x2B for 1250 Mb/s.
- R3: Each attempt issues one test-interface request with code 0x44. The data byte carries the range code in bits 6:1, with bits 7 and 0 at zero, so it is 0x12 for 750 Mb/s and 0x56 for 1250 Mb/s. Request, code and data stay stable until the acknowledge.
- R4: The reset phase runs in this order: clock-enable low, shutdown asserted (shutdown_n low), reset asserted (rst_n low), test-clear high, test-clear low, clock-enable high, shutdown_n high, rst_n high. Each step takes its own cycle, and a wait of at least the power-settle time follows.
- R5: PHY power rises no earlier than the power-settle time after the test-interface acknowledge. The lock check comes no earlier than the power-settle time after power-on. With lock low the attempt fails and the link is never enabled.
- R6: During configuration the block drives a lane mask of (1<<(lanes+1))−1 (0x1F for 4 lanes), a word count of twice the latched width and a data type of 0x1E, and it sets bypass mode.
- R7: The enable phase raises the PHY and link enables. At least the link-settle time later it pulses error-clear while leaving bypass. The error status is read at least the link-settle time after that.
- R8: A zero error status ends the sequence with done_o high. A failed attempt retries the full configuration until three attempts have been used, and then fail_o goes high. done_o and fail_o are never high together.
- R9: A stop pulse clears the PHY and link enables, drops done_o and returns the block to idle.
- R10: Every change of the PHY enable, the link enable or bypass mode happens in a cycle in which cfg_done_o is high.
- R11: PHY power is low whenever a test-interface request starts, so a retry power-cycles the PHY, and power rises once per attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| width_i | input | DIM_W | Active frame width, latched at start |
| height_i | input | DIM_W | Active frame height, latched at start |
| start_i | input | 1 | Start pulse, accepted when not busy |
| stop_i | input | 1 | Stop pulse, drops the enables |
| tif_ack_i | input | 1 | Test-interface master completion |
| pll_lock_i | input | 1 | PHY PLL lock status |
| err_status_i | input | ERR_W | Raw link error status |
| tif_req_o | output | 1 | Test-interface write request |
| tif_code_o | output | 8 | Test-interface code |
| tif_data_o | output | 8 | Test-interface data byte |
| phy_clk_en_o | output | 1 | PHY clock enable |
| phy_shutdown_n_o | output | 1 | PHY shutdown, active low |
| phy_rst_n_o | output | 1 | PHY reset, active low |
| phy_test_clr_o | output | 1 | PHY test-interface clear |
| phy_pwr_o | output | 1 | PHY power-on request |
| dphy_en_o | output | 1 | PHY lane enable |
| link_en_o | output | 1 | Link controller enable |
| bypass_o | output | 1 | Bypass mode select |
| err_clr_o | output | 1 | Error-flag clear strobe |
| cfg_done_o | output | 1 | Config-done strobe |
| lane_mask_o | output | LANES+1 | Lane-enable mask, clock lane included |
| word_cnt_o | output | DIM_W+1 | Packet word count |
| data_type_o | output | 8 | Packet data type |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Link up without errors |
| fail_o | output | 1 | All attempts failed |

## Verification
The rate choice is tried with the exact high-rate frame, frames one pixel off in each dimension, the transposed frame and common smaller sizes. Only the exact match may produce data byte 0x56. The retry logic is tried with errors that never occur, errors that persist and errors that clear on the third attempt, and with a lock that never comes. These four cases tell apart a correct attempt count from one that stops early, runs one attempt too many or ignores the lock. Each run measures the gaps between acknowledge, power-on, link enable, error clear and the final verdict against the settle times. It also checks the reset step order, the power-cycle on each retry, the config-done coverage and the effect of a stop.

// File: rtl/cam_tx_pkg.sv
package cam_tx_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_CLKOFF, S_SHDN, S_RST, S_CLR, S_UNCLR, S_CLKON, S_UNSHDN,
    S_UNRST, S_RWAIT, S_PREP, S_TIF, S_PWAIT1, S_PWRON, S_PWAIT2, S_LOCK,
    S_EN, S_LWAIT1, S_ECLR, S_LWAIT2, S_ECHK, S_RUN, S_FAILED
  } state_e;

  localparam int NUM_RANGES = 39;

  localparam logic [10:0] RANGE_MAX [NUM_RANGES] = '{
    11'd90,   11'd100,  11'd110,  11'd130,  11'd140,  11'd150,  11'd170,  11'd180,
    11'd200,  11'd220,  11'd240,  11'd250,  11'd270,  11'd300,  11'd330,  11'd360,
    11'd400,  11'd450,  11'd500,  11'd550,  11'd600,  11'd650,  11'd700,  11'd750,
    11'd800,  11'd850,  11'd900,  11'd950,  11'd1000, 11'd1050, 11'd1100, 11'd1150,
    11'd1200, 11'd1250, 11'd1300, 11'd1350, 11'd1400, 11'd1450, 11'd1500
  };

  localparam logic [5:0] RANGE_CODE [NUM_RANGES] = '{
    6'h00, 6'h10, 6'h20, 6'h01, 6'h11, 6'h21, 6'h02, 6'h12,
    6'h22, 6'h03, 6'h13, 6'h23, 6'h04, 6'h14, 6'h05, 6'h15,
    6'h25, 6'h06, 6'h16, 6'h07, 6'h17, 6'h08, 6'h18, 6'h09,
    6'h19, 6'h29, 6'h39, 6'h0a, 6'h1a, 6'h2a, 6'h3a, 6'h0b,
    6'h1b, 6'h2b, 6'h3b, 6'h0c, 6'h1c, 6'h2c, 6'h3c
  };

  // first entry whose limit covers the rate; fall back to the last one
  function automatic logic [5:0] range_code(input logic [10:0] rate);
    logic [5:0] code;
    logic       hit;
    code = RANGE_CODE[NUM_RANGES-1];
    hit  = 1'b0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (!hit && rate <= RANGE_MAX[i]) begin
        code = RANGE_CODE[i];
        hit  = 1'b1;
      end
    end
    return code;
  endfunction

endpackage

// File: rtl/cam_tx_rate_sel.sv
module cam_tx_rate_sel #(
  parameter int DIM_W   = 16,
  parameter int HI_W    = 3840,
  parameter int HI_H    = 2160,
  parameter int RATE_HI = 1250,
  parameter int RATE_LO = 750
) (
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  output logic [5:0]       code_o
);
  logic [10:0] rate;

  always_comb begin
    rate   = (width_i == DIM_W'(HI_W) && height_i == DIM_W'(HI_H)) ?
             11'(RATE_HI) : 11'(RATE_LO);
    code_o = cam_tx_pkg::range_code(rate);
  end
endmodule

// File: rtl/cam_tx_timer.sv
module cam_tx_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cam_tx_bringup.sv
module cam_tx_bringup #(
  parameter int          DIM_W        = 16,
  parameter int          LANES        = 4,
  parameter int          CLK_KHZ      = 100000,
  parameter int          PWR_WAIT_US  = 1500,
  parameter int          LINK_WAIT_MS = 40,
  parameter int          MAX_TRIES    = 3,
  parameter int          ERR_W        = 32,
  parameter logic [7:0]  RANGE_TCODE  = 8'h44,
  parameter logic [7:0]  PIX_DT       = 8'h1E
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIM_W-1:0] width_i,
  input  logic [DIM_W-1:0] height_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tif_ack_i,
  input  logic             pll_lock_i,
  input  logic [ERR_W-1:0] err_status_i,
  output logic             tif_req_o,
  output logic [7:0]       tif_code_o,
  output logic [7:0]       tif_data_o,
  output logic             phy_clk_en_o,
  output logic             phy_shutdown_n_o,
  output logic             phy_rst_n_o,
  output logic             phy_test_clr_o,
  output logic             phy_pwr_o,
  output logic             dphy_en_o,
  output logic             link_en_o,
  output logic             bypass_o,
  output logic             err_clr_o,
  output logic             cfg_done_o,
  output logic [LANES:0]   lane_mask_o,
  output logic [DIM_W:0]   word_cnt_o,
  output logic [7:0]       data_type_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o
);
  import cam_tx_pkg::*;

  localparam int T_PWR  = CLK_KHZ * PWR_WAIT_US / 1000;
  localparam int T_LINK = CLK_KHZ * LINK_WAIT_MS;
  localparam int T_MAX  = (T_PWR > T_LINK) ? T_PWR : T_LINK;
  localparam int TW     = $clog2(T_MAX + 1);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam logic [LANES:0] LANE_MASK = {(LANES+1){1'b1}};

  state_e             state_q;
  logic [DIM_W-1:0]   wid_q, hgt_q;
  logic [TRY_W-1:0]   att_q;
  logic [5:0]         code;
  logic               tmr_load, tmr_zero;
  logic [TW-1:0]      tmr_val;

  cam_tx_rate_sel #(.DIM_W(DIM_W)) u_rate (
    .width_i(wid_q), .height_i(hgt_q), .code_o(code)
  );

  always_comb begin
    tmr_load = (state_q == S_UNRST) || (state_q == S_PWRON) ||
               (state_q == S_TIF && tif_ack_i) ||
               (state_q == S_EN) || (state_q == S_ECLR);
    tmr_val  = (state_q == S_EN || state_q == S_ECLR) ? TW'(T_LINK) : TW'(T_PWR);
  end

  cam_tx_timer #(.TW(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val),
    .zero_o(tmr_zero)
  );

  assign busy_o     = !(state_q inside {S_IDLE, S_RUN, S_FAILED});
  assign tif_code_o = RANGE_TCODE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q          <= S_IDLE;
      wid_q            <= '0;
      hgt_q            <= '0;
      att_q            <= '0;
      tif_req_o        <= 1'b0;
      tif_data_o       <= '0;
      phy_clk_en_o     <= 1'b0;
      phy_shutdown_n_o <= 1'b0;
      phy_rst_n_o      <= 1'b0;
      phy_test_clr_o   <= 1'b0;
      phy_pwr_o        <= 1'b0;
      dphy_en_o        <= 1'b0;
      link_en_o        <= 1'b0;
      bypass_o         <= 1'b0;
      err_clr_o        <= 1'b0;
      cfg_done_o       <= 1'b0;
      lane_mask_o      <= '0;
      word_cnt_o       <= '0;
      data_type_o      <= '0;
      done_o           <= 1'b0;
      fail_o           <= 1'b0;
    end else begin
      cfg_done_o <= 1'b0;
      err_clr_o  <= 1'b0;
      if (stop_i) begin
        dphy_en_o  <= 1'b0;
        link_en_o  <= 1'b0;
        cfg_done_o <= 1'b1;
        tif_req_o  <= 1'b0;
        done_o     <= 1'b0;
        state_q    <= S_IDLE;
      end else begin
        unique case (state_q)
          S_IDLE, S_RUN, S_FAILED: if (start_i) begin
            wid_q   <= width_i;
            hgt_q   <= height_i;
            att_q   <= '0;
            done_o  <= 1'b0;
            fail_o  <= 1'b0;
            state_q <= S_CLKOFF;
          end
          S_CLKOFF: begin phy_clk_en_o     <= 1'b0; state_q <= S_SHDN;   end
          S_SHDN:   begin phy_shutdown_n_o <= 1'b0; state_q <= S_RST;    end
          S_RST:    begin phy_rst_n_o      <= 1'b0; state_q <= S_CLR;    end
          S_CLR:    begin phy_test_clr_o   <= 1'b1; state_q <= S_UNCLR;  end
          S_UNCLR:  begin phy_test_clr_o   <= 1'b0; state_q <= S_CLKON;  end
          S_CLKON:  begin phy_clk_en_o     <= 1'b1; state_q <= S_UNSHDN; end
          S_UNSHDN: begin phy_shutdown_n_o <= 1'b1; state_q <= S_UNRST;  end
          S_UNRST:  begin phy_rst_n_o      <= 1'b1; state_q <= S_RWAIT;  end
          S_RWAIT:  if (tmr_zero) state_q <= S_PREP;
          S_PREP: begin
            phy_pwr_o   <= 1'b0;
            dphy_en_o   <= 1'b0;
            link_en_o   <= 1'b0;
            bypass_o    <= 1'b1;
            cfg_done_o  <= 1'b1;
            lane_mask_o <= LANE_MASK;
            word_cnt_o  <= {wid_q, 1'b0};
            data_type_o <= PIX_DT;
            tif_data_o  <= {1'b0, code, 1'b0};
            tif_req_o   <= 1'b1;
            state_q     <= S_TIF;
          end
          S_TIF: if (tif_ack_i) begin
            tif_req_o <= 1'b0;
            state_q   <= S_PWAIT1;
          end
          S_PWAIT1: if (tmr_zero) state_q <= S_PWRON;
          S_PWRON:  begin phy_pwr_o <= 1'b1; state_q <= S_PWAIT2; end
          S_PWAIT2: if (tmr_zero) state_q <= S_LOCK;
          S_LOCK, S_ECHK: begin
            if ((state_q == S_LOCK && pll_lock_i) ||
                (state_q == S_ECHK && err_status_i == '0)) begin
              if (state_q == S_ECHK) done_o <= 1'b1;
              state_q <= (state_q == S_LOCK) ? S_EN : S_RUN;
            end else if (att_q == TRY_W'(MAX_TRIES - 1)) begin
              fail_o  <= 1'b1;
              state_q <= S_FAILED;
            end else begin
              att_q   <= att_q + 1'b1;
              state_q <= S_PREP;
            end
          end
          S_EN: begin
            dphy_en_o  <= 1'b1;
            link_en_o  <= 1'b1;
            cfg_done_o <= 1'b1;
            state_q    <= S_LWAIT1;
          end
          S_LWAIT1: if (tmr_zero) state_q <= S_ECLR;
          S_ECLR: begin
            err_clr_o  <= 1'b1;
            bypass_o   <= 1'b0;
            cfg_done_o <= 1'b1;
            state_q    <= S_LWAIT2;
          end
          S_LWAIT2: if (tmr_zero) state_q <= S_ECHK;
          default:  state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cam_tx_bringup_chk.sv
module cam_tx_bringup_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tif_req_o,
  input logic       tif_ack_i,
  input logic [7:0] tif_code_o,
  input logic [7:0] tif_data_o,
  input logic       phy_clk_en_o,
  input logic       phy_shutdown_n_o,
  input logic       phy_rst_n_o,
  input logic       phy_test_clr_o,
  input logic       phy_pwr_o,
  input logic       pll_lock_i,
  input logic       dphy_en_o,
  input logic       link_en_o,
  input logic       bypass_o,
  input logic       err_clr_o,
  input logic       cfg_done_o,
  input logic       done_o,
  input logic       fail_o
);
  p_tif_fmt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tif_req_o |-> (tif_code_o == 8'h44 && !tif_data_o[7] && !tif_data_o[0]));

  p_tif_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tif_req_o && !tif_ack_i) |=> (tif_req_o && $stable(tif_data_o)));

  p_rst_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_rst_n_o) |-> (phy_shutdown_n_o && phy_clk_en_o && !phy_test_clr_o));

  p_shdn_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_shutdown_n_o) |-> (phy_clk_en_o && !phy_test_clr_o && !phy_rst_n_o));

  p_lock_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_en_o) |-> (phy_pwr_o && $past(pll_lock_i)));

  p_err_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_o |-> (!bypass_o && link_en_o && dphy_en_o));

  p_verdict_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  p_cfg_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dphy_en_o != $past(dphy_en_o)) || (link_en_o != $past(link_en_o)) ||
     (bypass_o != $past(bypass_o))) |-> cfg_done_o);

  p_pwr_cycle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tif_req_o) |-> !phy_pwr_o);
endmodule

bind cam_tx_bringup cam_tx_bringup_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tif_req_o(tif_req_o), .tif_ack_i(tif_ack_i),
  .tif_code_o(tif_code_o), .tif_data_o(tif_data_o), .phy_clk_en_o(phy_clk_en_o),
  .phy_shutdown_n_o(phy_shutdown_n_o), .phy_rst_n_o(phy_rst_n_o),
  .phy_test_clr_o(phy_test_clr_o), .phy_pwr_o(phy_pwr_o), .pll_lock_i(pll_lock_i),
  .dphy_en_o(dphy_en_o), .link_en_o(link_en_o), .bypass_o(bypass_o),
  .err_clr_o(err_clr_o), .cfg_done_o(cfg_done_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/cam_tx_bringup_bench.sv
module cam_tx_bringup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int KHZ        = 10;
  localparam int T_PWR      = KHZ * 1500 / 1000;
  localparam int T_LINK     = KHZ * 40;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] width_i = '0, height_i = '0;
  logic        start_i = 1'b0, stop_i = 1'b0, tif_ack_i = 1'b0, pll_lock_i = 1'b1;
  logic [31:0] err_status_i;
  logic        tif_req_o, phy_clk_en_o, phy_shutdown_n_o, phy_rst_n_o, phy_test_clr_o;
  logic        phy_pwr_o, dphy_en_o, link_en_o, bypass_o, err_clr_o, cfg_done_o;
  logic        busy_o, done_o, fail_o;
  logic [7:0]  tif_code_o, tif_data_o, data_type_o;
  logic [4:0]  lane_mask_o;
  logic [16:0] word_cnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_tx_bringup #(.CLK_KHZ(KHZ)) u_cam_tx_bringup (
    .clk_i(clk), .rst_ni(rst_ni), .width_i(width_i), .height_i(height_i),
    .start_i(start_i), .stop_i(stop_i), .tif_ack_i(tif_ack_i),
    .pll_lock_i(pll_lock_i), .err_status_i(err_status_i),
    .tif_req_o(tif_req_o), .tif_code_o(tif_code_o), .tif_data_o(tif_data_o),
    .phy_clk_en_o(phy_clk_en_o), .phy_shutdown_n_o(phy_shutdown_n_o),
    .phy_rst_n_o(phy_rst_n_o), .phy_test_clr_o(phy_test_clr_o),
    .phy_pwr_o(phy_pwr_o), .dphy_en_o(dphy_en_o), .link_en_o(link_en_o),
    .bypass_o(bypass_o), .err_clr_o(err_clr_o), .cfg_done_o(cfg_done_o),
    .lane_mask_o(lane_mask_o), .word_cnt_o(word_cnt_o), .data_type_o(data_type_o),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

  int checks = 0, fails = 0;
  int cyc = 0, attempts = 0, pwr_rises = 0, ack_dly = 0, err_mode = 0;
  int ack_cyc = 0, pwr_cyc = 0, link_cyc = 0, eclr_cyc = 0;
  int clr_r = 0, clr_f = 0, clk_r = 0, shd_r = 0, rst_r = 0;
  int cfg_viol = 0, pwr_viol = 0;
  logic timeout = 1'b0;
  logic p_req = 0, p_pwr = 0, p_link = 0, p_dphy = 0, p_byp = 0;
  logic p_clr = 0, p_clk = 0, p_shd = 0, p_rst = 0;

  // error source: 0 never, 1 always, 2 only on the first two attempts
  assign err_status_i = (err_mode == 1) ? 32'h4 :
                        (err_mode == 2 && attempts < 3) ? 32'h100 : 32'h0;

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    timeout = 1'b1;
  end

  // monitor and test-interface responder, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (tif_req_o && !p_req) begin
      attempts++;
      if (phy_pwr_o) pwr_viol++;
    end
    if (phy_pwr_o && !p_pwr) begin pwr_rises++; pwr_cyc = cyc; end
    if (link_en_o && !p_link) link_cyc = cyc;
    if (err_clr_o) eclr_cyc = cyc;
    if (phy_test_clr_o && !p_clr) clr_r = cyc;
    if (!phy_test_clr_o && p_clr) clr_f = cyc;
    if (phy_clk_en_o && !p_clk) clk_r = cyc;
    if (phy_shutdown_n_o && !p_shd) shd_r = cyc;
    if (phy_rst_n_o && !p_rst) rst_r = cyc;
    if ((link_en_o != p_link || dphy_en_o != p_dphy || bypass_o != p_byp) && !cfg_done_o)
      cfg_viol++;
    if (tif_ack_i) begin
      tif_ack_i = 1'b0;
      ack_dly = 0;
    end else if (tif_req_o) begin
      ack_dly++;
      if (ack_dly == 2) begin tif_ack_i = 1'b1; ack_cyc = cyc; end
    end
    p_req = tif_req_o; p_pwr = phy_pwr_o; p_link = link_en_o; p_dphy = dphy_en_o;
    p_byp = bypass_o; p_clr = phy_test_clr_o; p_clk = phy_clk_en_o;
    p_shd = phy_shutdown_n_o; p_rst = phy_rst_n_o;
  end

  task automatic run_case(input int w, input int h, input int emode, input logic lock);
    int exp_att;
    int end_cyc;
    logic hi;
    logic exp_done;
    @(negedge clk);
    width_i = 16'(w); height_i = 16'(h); err_mode = emode; pll_lock_i = lock;
    attempts = 0; pwr_rises = 0; cfg_viol = 0; pwr_viol = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!(done_o || fail_o) && !timeout) @(negedge clk);
    end_cyc  = cyc;
    hi       = (w == 3840 && h == 2160);
    exp_done = lock && (emode != 1);
    exp_att  = (exp_done && emode == 0) ? 1 : 3;
    chk("R1/R2/R3 data byte", tif_data_o == (hi ? 8'h56 : 8'h12), tif_data_o, hi ? 8'h56 : 8'h12);
    chk("R3 test code", tif_code_o == 8'h44, tif_code_o, 8'h44);
    chk("R4 reset order", clr_r < clr_f && clr_f < clk_r && clk_r < shd_r && shd_r < rst_r,
        rst_r - clr_r, 4);
    chk("R4 reset settle", ack_cyc - rst_r >= T_PWR, ack_cyc - rst_r, T_PWR);
    chk("R5 power settle", pwr_cyc - ack_cyc >= T_PWR, pwr_cyc - ack_cyc, T_PWR);
    chk("R6 lane mask", lane_mask_o == 5'h1F, lane_mask_o, 5'h1F);
    chk("R6 word count", word_cnt_o == 17'(2 * w), word_cnt_o, 2 * w);
    chk("R6 data type", data_type_o == 8'h1E, data_type_o, 8'h1E);
    chk("R8 attempts", attempts == exp_att, attempts, exp_att);
    chk("R8 done", done_o == exp_done, done_o, exp_done);
    chk("R8 fail", fail_o == !exp_done, fail_o, !exp_done);
    chk("R10 cfg strobe", cfg_viol == 0, cfg_viol, 0);
    chk("R11 power cycle", pwr_viol == 0 && pwr_rises == exp_att, pwr_rises, exp_att);
    if (lock) begin
      chk("R7 link settle", eclr_cyc - link_cyc >= T_LINK, eclr_cyc - link_cyc, T_LINK);
      chk("R7 check settle", end_cyc - eclr_cyc >= T_LINK, end_cyc - eclr_cyc, T_LINK);
      chk("R7 bypass left", bypass_o == 1'b0, bypass_o, 0);
    end else begin
      chk("R5 no link without lock", link_en_o == 1'b0, link_en_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset busy", busy_o == 1'b0, busy_o, 0);
    chk("reset enables", {dphy_en_o, link_en_o, phy_pwr_o, tif_req_o} == 4'b0,
        {dphy_en_o, link_en_o, phy_pwr_o, tif_req_o}, 0);
    chk("reset verdict", {done_o, fail_o} == 2'b0, {done_o, fail_o}, 0);
    rst_ni = 1'b1;
    run_case(3840, 2160, 0, 1'b1);
    run_case(1920, 1080, 0, 1'b1);
    run_case(3840, 2161, 0, 1'b1);
    run_case(3839, 2160, 2, 1'b1);
    run_case(2160, 3840, 1, 1'b1);
    run_case(3840, 2160, 0, 1'b0);
    run_case(640, 480, 2, 1'b1);
    run_case(3840, 2160, 2, 1'b1);
    // R9: stop drops the enables and the verdict
    @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    @(negedge clk);
    chk("R9 enables cleared", {dphy_en_o, link_en_o} == 2'b0, {dphy_en_o, link_en_o}, 0);
    chk("R9 done cleared", done_o == 1'b0 && busy_o == 1'b0, {done_o, busy_o}, 0);
    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule